// File: doc/BRIEF.md
# Operation Sampling Interval Selector

This block watches a stream of retiring operations and tags one of them for profiling at a programmable interval. A down-counter counts the operations of the chosen population. That population is either every retiring micro-operation or only the micro-operations that complete an architectural instruction. When the counter reaches its last step, the current operation is picked and the counter reloads. The reload value is the programmed interval, raised to a minimum where needed. When jitter is enabled, a small pseudo-random offset is added to each reload so that the sampling does not lock onto loop periods.

Only one tagged operation may be outstanding at a time. A picked operation sets an in-flight flag, and a sample-complete strobe from the record collector clears it. If the counter expires while the flag is still set, the pick is dropped and a collision pulse is raised. A saturating collision counter records these drops. A collision is counted whether or not a later filter would have kept the record.

Top module: `op_sample_sel`

## Requirements
- R1: After synchronous reset, `sample_tag`, `collision` and `coll_count` are 0 and the in-flight flag is clear. The first pick falls on the Nth counted operation after reset, where N is the clamped interval present during reset. No jitter is applied to this first count.
- R2: With `pop_sel`=1 every `op_valid` cycle is counted. With `pop_sel`=0 only `op_valid` cycles with `op_arch`=1 are counted, and all other operations have no effect on the counter.
- R3: An `interval` value below MIN_IVL (default 4), including 0, behaves exactly as MIN_IVL.
- R4: The counter reloads on every expiry, whether the pick was taken or dropped. The reload value is the clamped `interval` sampled in the expiry cycle. With jitter off, picks fall exactly every clamped-interval counted operations.
- R5: A 16-bit LFSR is seeded to 0xACE1 at reset. It steps once per expiry, with next = {q[14:0], q[15]^q[13]^q[12]^q[10]}. With `jitter_en`=1, each reload adds the value of q[3:0] from before the step.
- R6: An expiry while the in-flight flag is set and `sample_done` is low produces no tag. It produces one `collision` pulse and adds one to `coll_count`.
- R7: `sample_done` clears the in-flight flag. An expiry in the same cycle as `sample_done` is taken as a normal pick, with a tag and no collision, and the flag stays set.
- R8: `coll_count` saturates at 2^CNT_W-1 and holds there while further collisions occur.
- R9: `coll_clr` sets `coll_count` to 0 on the next edge and takes priority over an increment in the same cycle.
- R10: `sample_tag` and `collision` are registered one-cycle pulses. Each appears in the cycle after the operation strobe that caused it, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One operation retires this cycle |
| op_arch | input | 1 | The retiring operation completes an architectural instruction |
| pop_sel | input | 1 | Population: 0 architectural instructions, 1 micro-operations |
| interval | input | IW | Programmed sampling interval in counted operations |
| jitter_en | input | 1 | Add pseudo-random offset to each reload |
| sample_done | input | 1 | The outstanding sample has been collected |
| coll_clr | input | 1 | Synchronous clear of the collision counter |
| sample_tag | output | 1 | Pulse: the previous cycle's operation is sampled |
| collision | output | 1 | Pulse: the previous cycle's pick was dropped |
| coll_count | output | CNT_W | Saturating count of dropped picks |

## Verification
The assertions assume that `sample_done` may arrive at any time, including when no sample is outstanding. They also assume that `interval`, `pop_sel` and `jitter_en` may change in any cycle. They therefore check only the counter's range, the in-flight flag's hold and clear behaviour, pulse exclusivity and the counter's monotonic, saturating behaviour. The random stimulus changes the interval, including values below the minimum, at phase boundaries and within phases. It drives `sample_done` with varied probabilities, so collisions, same-cycle completions and spurious completions all occur. Directed phases align `sample_done` with predicted expiries and hold it low long enough to reach saturation with a narrowed counter.

// File: rtl/ossel_pkg.sv
package ossel_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic {
    POP_ARCH = 1'b0,
    POP_UOP  = 1'b1
  } pop_e;

  // Fibonacci LFSR, taps 16,14,13,11 (maximal length)
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] q);
    return {q[LFSR_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

endpackage

// File: rtl/ossel_jitter.sv
module ossel_jitter
  import ossel_pkg::*;
#(
  parameter int JIT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic enable,
  output logic [(JIT_W > 0 ? JIT_W : 1)-1:0] jit
);

  localparam int OW = (JIT_W > 0) ? JIT_W : 1;

  generate
    if (JIT_W > 0) begin : g_lfsr
      logic [LFSR_W-1:0] lfsr_q;

      always_ff @(posedge clk) begin
        if (rst)      lfsr_q <= LFSR_SEED;
        else if (adv) lfsr_q <= lfsr_next(lfsr_q);
      end

      assign jit = enable ? lfsr_q[OW-1:0] : '0;

      // R5
      lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
      // R5
      lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(lfsr_q));
    end else begin : g_none
      assign jit = '0;
    end
  endgenerate

endmodule

// File: rtl/ossel_interval_ctr.sv
module ossel_interval_ctr #(
  parameter int IW      = 16,
  parameter int MIN_IVL = 4,
  parameter int JIT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                count_en,
  input  logic [IW-1:0]       interval,
  input  logic [(JIT_W > 0 ? JIT_W : 1)-1:0] jit,
  output logic                expire
);

  localparam int OW = (JIT_W > 0) ? JIT_W : 1;
  localparam int CW = IW + 1;
  localparam logic [IW-1:0] MIN_V = IW'(MIN_IVL);
  localparam logic [CW-1:0] MAX_RELOAD = CW'({IW{1'b1}}) + CW'({OW{1'b1}});

  logic [IW-1:0] base;
  logic [CW-1:0] reload;
  logic [CW-1:0] cnt_q;

  always_comb begin
    base   = (interval < MIN_V) ? MIN_V : interval;
    reload = CW'(base) + CW'(jit);
  end

  assign expire = count_en && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CW'(base);
    end else if (count_en) begin
      if (cnt_q == CW'(1)) cnt_q <= reload;
      else                 cnt_q <= cnt_q - CW'(1);
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) && (cnt_q <= MAX_RELOAD));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> $stable(cnt_q));

endmodule

// File: rtl/ossel_inflight.sv
module ossel_inflight (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic sample_done,
  output logic tag_q,
  output logic coll_q,
  output logic coll_now
);

  logic busy_q;
  logic take;

  always_comb begin
    take     = expire && (!busy_q || sample_done);
    coll_now = expire && busy_q && !sample_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tag_q  <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      tag_q  <= take;
      coll_q <= coll_now;
      if (take)             busy_q <= 1'b1;
      else if (sample_done) busy_q <= 1'b0;
    end
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !sample_done) |=> busy_q);
  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_done && !expire) |=> !busy_q);
  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tag_q && coll_q));

endmodule

// File: rtl/ossel_coll_ctr.sv
module ossel_coll_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] MAX_V = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt_q <= '0;
    else if (inc && cnt_q != MAX_V)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAX_V && !clr) |=> cnt_q == MAX_V);
  // R8
  monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_q >= $past(cnt_q));
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/op_sample_sel.sv
module op_sample_sel
  import ossel_pkg::*;
#(
  parameter int IW      = 16,
  parameter int MIN_IVL = 4,
  parameter int JIT_W   = 4,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_arch,
  input  logic             pop_sel,
  input  logic [IW-1:0]    interval,
  input  logic             jitter_en,
  input  logic             sample_done,
  input  logic             coll_clr,
  output logic             sample_tag,
  output logic             collision,
  output logic [CNT_W-1:0] coll_count
);

  localparam int OW = (JIT_W > 0) ? JIT_W : 1;

  logic          count_en;
  logic          expire;
  logic          coll_now;
  logic [OW-1:0] jit;

  assign count_en = op_valid && ((pop_e'(pop_sel) == POP_UOP) || op_arch);

  ossel_jitter #(.JIT_W(JIT_W)) u_jitter (
    .clk    (clk),
    .rst    (rst),
    .adv    (expire),
    .enable (jitter_en),
    .jit    (jit)
  );

  ossel_interval_ctr #(.IW(IW), .MIN_IVL(MIN_IVL), .JIT_W(JIT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .interval (interval),
    .jit      (jit),
    .expire   (expire)
  );

  ossel_inflight u_inflight (
    .clk         (clk),
    .rst         (rst),
    .expire      (expire),
    .sample_done (sample_done),
    .tag_q       (sample_tag),
    .coll_q      (collision),
    .coll_now    (coll_now)
  );

  ossel_coll_ctr #(.CNT_W(CNT_W)) u_coll (
    .clk   (clk),
    .rst   (rst),
    .inc   (coll_now),
    .clr   (coll_clr),
    .cnt_q (coll_count)
  );

  // R10
  tag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sample_tag |-> $past(op_valid));

endmodule

// File: tb/op_sample_sel_tb.sv
`timescale 1ns/1ps
module op_sample_sel_tb;

  localparam int IW = 16;
  localparam int MIN_IVL = 4;
  localparam int CNT_W = 6;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 0, op_arch = 0, pop_sel = 1, jitter_en = 0;
  logic sample_done = 0, coll_clr = 0;
  logic [IW-1:0] interval = 16'd10;
  logic sample_tag, collision;
  logic [CNT_W-1:0] coll_count;

  always #2.5 clk = ~clk;

  op_sample_sel #(.IW(IW), .MIN_IVL(MIN_IVL), .JIT_W(4), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_arch(op_arch),
    .pop_sel(pop_sel), .interval(interval), .jitter_en(jitter_en),
    .sample_done(sample_done), .coll_clr(coll_clr),
    .sample_tag(sample_tag), .collision(collision), .coll_count(coll_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 0;

  // model state
  int m_cnt;
  bit m_busy;
  longint m_coll;
  logic [15:0] m_lfsr;
  int n_tags, n_colls;

  function automatic int clamp_ivl(input logic [IW-1:0] v);
    return (v < MIN_IVL) ? MIN_IVL : int'(v);
  endfunction

  function automatic logic [15:0] lfsr_step(input logic [15:0] q);
    return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

  task automatic check(input longint act, input longint exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; op_valid = 0; sample_done = 0; coll_clr = 0;
    @(posedge clk); @(posedge clk); #1;
    m_cnt = clamp_ivl(interval);
    m_busy = 0; m_coll = 0; m_lfsr = 16'hACE1;
    @(negedge clk); rst = 0;
  endtask

  task automatic step(input bit v, input bit a, input bit d, input bit c, input string req);
    bit counted, expv, take, coll;
    longint ncoll;
    @(negedge clk);
    op_valid = v; op_arch = a; sample_done = d; coll_clr = c;
    counted = v && (pop_sel || a);
    expv = counted && (m_cnt == 1);
    take = expv && (!m_busy || d);
    coll = expv && m_busy && !d;
    ncoll = c ? 0 : ((coll && m_coll < CMAX) ? m_coll + 1 : m_coll);
    @(posedge clk); #1;
    check(sample_tag, take, {req, " tag"});
    check(collision, coll, {req, " collision"});
    check(coll_count, ncoll, {req, " coll_count"});
    if (take) n_tags++;
    if (coll) n_colls++;
    if (counted) begin
      if (expv) begin
        m_cnt = clamp_ivl(interval) + (jitter_en ? int'(m_lfsr[3:0]) : 0);
        m_lfsr = lfsr_step(m_lfsr);
      end else m_cnt--;
    end
    if (take) m_busy = 1;
    else if (d) m_busy = 0;
    m_coll = ncoll;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check(sample_tag, 0, "R1 reset tag");
    check(collision, 0, "R1 reset collision");
    check(coll_count, 0, "R1 reset count");
    interval = 16'd10; pop_sel = 1; jitter_en = 0;
    do_reset();
    // R1/R4: first pick on 10th op, then every 10 with prompt completion
    for (int i = 0; i < 60; i++) step(1, 0, (i % 10) == 3, 0, "R1/R4 period");

    // R3: interval below minimum behaves as minimum
    interval = 16'd1; do_reset();
    for (int i = 0; i < 40; i++) step(1, 0, 1, 0, "R3 clamp 1");
    interval = 16'd0; do_reset();
    for (int i = 0; i < 40; i++) step(1, 0, 1, 0, "R3 clamp 0");

    // R2: architectural population ignores non-arch micro-ops
    interval = 16'd5; pop_sel = 0; do_reset();
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, 1, 0, "R2 arch pop");
    pop_sel = 1;
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, 1, 0, "R2 uop pop");

    // R6: no completion, expiries collide
    interval = 16'd6; do_reset();
    n_colls = 0;
    for (int i = 0; i < 80; i++) step(1, 1, 0, 0, "R6 collide");
    check(n_colls > 5, 1, "R6 collisions seen");

    // R7: completion aligned with expiry while busy
    interval = 16'd4; do_reset();
    n_tags = 0;
    for (int i = 0; i < 60; i++) step(1, 1, (m_cnt == 1) && m_busy, 0, "R7 same-cycle done");
    check(n_tags, 15, "R7 tags with aligned done");

    // R5: jitter on
    interval = 16'd8; jitter_en = 1; do_reset();
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 4) != 0, 1, $urandom_range(0, 5) == 0, 0, "R5 jitter");
    jitter_en = 0;

    // R8: saturation then R9 clear
    interval = 16'd4; do_reset();
    for (int i = 0; i < 400; i++) step(1, 1, 0, 0, "R8 saturate");
    check(coll_count, CMAX, "R8 saturated value");
    step(1, 1, 0, 1, "R9 clear");
    for (int i = 0; i < 20; i++) step(1, 1, 0, (m_cnt == 1), "R9 clear beats inc");
    step(0, 0, 0, 1, "R9 clear idle");
    check(coll_count, 0, "R9 cleared");

    // R10 and mixed: random everything
    do_reset();
    for (int i = 0; i < 8000; i++) begin
      if ((i % 500) == 0) begin
        interval = 16'($urandom_range(0, 24));
        pop_sel = $urandom_range(0, 1);
        jitter_en = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 99) == 0) interval = 16'($urandom_range(0, 24));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7) == 0,
           $urandom_range(0, 199) == 0, "R10 random");
    end

    done_flag = 1;
    summary();
    $finish;
  end

endmodule